// File: doc/BRIEF.md
# Down-Counting Timer Channel

One channel of a memory-mapped system timer. A counter, 32 bits wide by default, is preset from a start-value register. It then counts down by one on every cycle where the channel tick input is high and the channel is running. The channel has two modes. In continuous mode the counter returns to the start value after reaching zero, which gives a periodic event. In single mode the counter stops at zero, which gives a one-off timeout.

Reaching zero sets a pending flag. The flag drives a level interrupt through a mask. Software removes the flag with a clear operation that takes several cycles. A busy bit stays visible during the clear, and software polls it before touching the flag again. A separate restart register reloads the counter on demand. A timer instance places several identical copies of this channel at separate base offsets; that decoding sits outside this block.

The bus is a plain single-cycle write strobe and read strobe with a word address. Read data appears one cycle after the read strobe.

Top module: `dtimer_channel`

## Requirements
- R1: After synchronous reset the register values are: mode 0, start value all ones, run 0, count all ones, status 0, mask 1, read data 0 and interrupt 0.
- R2: Word address 0 holds the mode in bit 0: 0 selects continuous and 1 selects single. It reads back with all other bits 0.
- R3: Writing 1 to bit 0 of the run register (address 2) while the channel is stopped copies the start value (address 1) into the counter. Writing 1 while the channel already runs has no such effect. The counter decrements only when run is 1 and tick is high. Otherwise it holds.
- R4: A write of any data to the restart register (address 3) copies the start value into the counter at the next edge. This takes priority over a tick. Address 3 reads as 0.
- R5: In continuous mode, a tick that takes the counter from 1 to 0 sets pending. The next tick at zero reloads the start value.
- R6: In single mode, reaching zero sets pending and then holds the counter at 0. The counter restarts only after a write to the restart register or after run is re-enabled.
- R7: The status register (address 5) reads pending in bit 0 and busy in bit 1. Writing 1 to bit 0 when not busy raises busy for exactly 3 cycles. Pending and busy then fall together. Writing 0 does nothing.
- R8: While busy is high, writes to the status register are ignored. A count that reaches zero during the clear leaves pending set once the clear ends.
- R9: The interrupt output is a register. It equals pending AND NOT mask from the previous cycle. The mask is bit 0 of address 6, where 1 blocks the interrupt.
- R10: A read strobe loads the selected register into the read data one cycle later. The register map is: 4 = live count. Addresses 3 and 7 read as 0. The read data holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Channel count enable, one step per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address within the channel |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The counter is tested with three tick patterns: every cycle, every third cycle, and none. These show whether decrements follow the tick or the clock, and whether a stopped tick really holds the count. Continuous and single runs with small start values tell an automatic reload apart from a hold at zero. Both restart paths, the restart register and re-enabling run, are then exercised after a halt. Clear operations are tried in three ways: a lone clear, a back-to-back second clear, and a clear that overlaps a terminal count. These separate a correct busy window from one that restarts, and a preserved late event from one that is lost.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE    = 3'd0,
    A_START   = 3'd1,
    A_RUN     = 3'd2,
    A_RESTART = 3'd3,
    A_COUNT   = 3'd4,
    A_STATUS  = 3'd5,
    A_MASK    = 3'd6
  } dtimer_addr_e;

  typedef enum logic {
    MODE_CONT   = 1'b0,
    MODE_SINGLE = 1'b1
  } dtimer_mode_e;
endpackage

// File: rtl/dtimer_count.sv
module dtimer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             single,
  input  logic             force_load,
  input  logic [CNT_W-1:0] start_val,
  output logic [CNT_W-1:0] count,
  output logic             halted,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic active;

  always_comb begin
    active = run && !halted && tick && !force_load;
    hit    = active && (count == ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '1;
      halted <= 1'b0;
    end else if (force_load) begin
      count  <= start_val;
      halted <= 1'b0;
    end else if (active) begin
      if (count == '0) count <= start_val;
      else             count <= count - ONE;
      if (hit && single) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/dtimer_flag.sv
module dtimer_flag #(
  parameter int CLR_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr_req,
  input  logic mask,
  output logic pending,
  output logic busy,
  output logic irq
);
  localparam int CCW = $clog2(CLR_CYCLES + 1);

  logic [CCW-1:0] left;
  logic           late;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      busy    <= 1'b0;
      late    <= 1'b0;
      left    <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= pending && !mask;
      if (busy) begin
        if (left == '0) begin
          busy    <= 1'b0;
          pending <= late || hit;
          late    <= 1'b0;
        end else begin
          left <= left - CCW'(1);
          if (hit) late <= 1'b1;
        end
      end else begin
        if (hit) pending <= 1'b1;
        if (clr_req) begin
          busy <= 1'b1;
          left <= CCW'(CLR_CYCLES - 1);
          late <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dtimer_channel.sv
module dtimer_channel
  import dtimer_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int CLR_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  dtimer_mode_e     mode_q;
  logic [CNT_W-1:0] start_q;
  logic             run_q;
  logic             mask_q;
  logic [CNT_W-1:0] count;
  logic             halted;
  logic             hit;
  logic             pending;
  logic             clr_busy;
  logic             force_load;
  logic             clr_req;
  logic [CNT_W-1:0] rd_mux;

  always_comb begin
    force_load = bus_wr && ((bus_addr == A_RESTART) ||
                 ((bus_addr == A_RUN) && bus_wdata[0] && !run_q));
    clr_req    = bus_wr && (bus_addr == A_STATUS) && bus_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_CONT;
      start_q <= '1;
      run_q   <= 1'b0;
      mask_q  <= 1'b1;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE:  mode_q  <= dtimer_mode_e'(bus_wdata[0]);
        A_START: start_q <= bus_wdata;
        A_RUN:   run_q   <= bus_wdata[0];
        A_MASK:  mask_q  <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  dtimer_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .run        (run_q),
    .single     (mode_q == MODE_SINGLE),
    .force_load (force_load),
    .start_val  (start_q),
    .count      (count),
    .halted     (halted),
    .hit        (hit)
  );

  dtimer_flag #(.CLR_CYCLES(CLR_CYCLES)) u_flag (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit),
    .clr_req (clr_req),
    .mask    (mask_q),
    .pending (pending),
    .busy    (clr_busy),
    .irq     (irq)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_MODE:   rd_mux[0] = mode_q;
      A_START:  rd_mux    = start_q;
      A_RUN:    rd_mux[0] = run_q;
      A_COUNT:  rd_mux    = count;
      A_STATUS: rd_mux[1:0] = {clr_busy, pending};
      A_MASK:   rd_mux[0] = mask_q;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/dtimer_channel_chk.sv
module dtimer_channel_chk #(
  parameter int CNT_W      = 32,
  parameter int CLR_CYCLES = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             pending,
  input logic             irq,
  input logic             mask,
  input logic             hit,
  input logic             single,
  input logic             halted,
  input logic             force_load,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] start_val
);
  localparam int LW = $clog2(CLR_CYCLES + 2);
  logic [LW-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + LW'(1);
    else           busy_len <= '0;
  end

  assert_busy_stays_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && busy_len < LW'(CLR_CYCLES - 1)) |=> busy);
  assert_busy_ends_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && busy_len == LW'(CLR_CYCLES - 1)) |=> !busy);
  assert_pend_falls_with_busy_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(pending) |-> ($past(busy) && !busy));
  assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(pending) && !$past(mask)));
  assert_restart_loads_R4: assert property (@(posedge clk) disable iff (rst)
    force_load |=> (count == $past(start_val)));
  assert_single_halts_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && single) |=> halted);
  assert_halt_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (halted && !force_load) |=> $stable(count));
endmodule

bind dtimer_channel dtimer_channel_chk #(.CNT_W(CNT_W), .CLR_CYCLES(CLR_CYCLES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (clr_busy),
  .pending    (pending),
  .irq        (irq),
  .mask       (mask_q),
  .hit        (hit),
  .single     (mode_q == dtimer_pkg::MODE_SINGLE),
  .halted     (halted),
  .force_load (force_load),
  .count      (count),
  .start_val  (start_q)
);

// File: tb/dtimer_channel_tb.sv
module dtimer_channel_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int tick_every = 1;
  bit tick_on = 1'b1;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dtimer_channel u_dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference state
  logic [31:0] m_cnt, m_start, m_rdata;
  bit m_mode, m_run, m_mask, m_halt, m_pend, m_busy, m_late, m_irq;
  int m_left;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tick = tick_on && (cyc % tick_every == 0);
    if (!rst) begin
      chk("R10 read data vs model", bus_rdata, m_rdata);
      chk("R9 irq vs model", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '1; m_start = '1; m_rdata = '0; m_mode = 0; m_run = 0;
      m_mask = 1; m_halt = 0; m_pend = 0; m_busy = 0; m_late = 0;
      m_irq = 0; m_left = 0;
    end else begin
      logic [31:0] rv;
      bit fl, act, hit, nirq;
      case (bus_addr)
        3'd0: rv = {31'd0, m_mode};
        3'd1: rv = m_start;
        3'd2: rv = {31'd0, m_run};
        3'd4: rv = m_cnt;
        3'd5: rv = {30'd0, m_busy, m_pend};
        3'd6: rv = {31'd0, m_mask};
        default: rv = 0;
      endcase
      if (bus_rd) m_rdata = rv;
      nirq = m_pend && !m_mask;
      fl  = bus_wr && (bus_addr == 3 || (bus_addr == 2 && bus_wdata[0] && !m_run));
      act = m_run && !m_halt && tick && !fl;
      hit = act && m_cnt == 1;
      if (fl) begin
        m_cnt = m_start; m_halt = 0;
      end else if (act) begin
        if (m_cnt == 0) m_cnt = m_start; else m_cnt = m_cnt - 1;
        if (hit && m_mode) m_halt = 1;
      end
      if (m_busy) begin
        if (m_left == 0) begin
          m_busy = 0; m_pend = m_late || hit; m_late = 0;
        end else begin
          m_left--; if (hit) m_late = 1;
        end
      end else begin
        if (hit) m_pend = 1;
        if (bus_wr && bus_addr == 5 && bus_wdata[0]) begin
          m_busy = 1; m_left = 2; m_late = 0;
        end
      end
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_mode = bus_wdata[0];
          3'd1: m_start = bus_wdata;
          3'd2: m_run = bus_wdata[0];
          3'd6: m_mask = bus_wdata[0];
          default: ;
        endcase
      end
      m_irq = nirq;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd_chk(3'd0, 32'd0, "R1 mode");
    rd_chk(3'd1, 32'hFFFF_FFFF, "R1 start value");
    rd_chk(3'd2, 32'd0, "R1 run");
    rd_chk(3'd4, 32'hFFFF_FFFF, "R1 count");
    rd_chk(3'd5, 32'd0, "R1 status");
    rd_chk(3'd6, 32'd1, "R1 mask");
    // R10 unused addresses
    rd_chk(3'd3, 32'd0, "R10 restart reads zero");
    rd_chk(3'd7, 32'd0, "R10 address 7 reads zero");
    // R2 mode bit
    wr(3'd0, 32'd3);
    rd_chk(3'd0, 32'd1, "R2 mode single");
    wr(3'd0, 32'd0);
    rd_chk(3'd0, 32'd0, "R2 mode continuous");
    // R4 restart with channel stopped, any data
    wr(3'd1, 32'd5); wr(3'd3, 32'd0);
    rd_chk(3'd4, 32'd5, "R4 restart data 0");
    wr(3'd1, 32'd9); wr(3'd3, 32'd1);
    rd_chk(3'd4, 32'd9, "R4 restart data 1");
    // R3 enable loads, no tick holds
    tick_on = 1'b0;
    wr(3'd1, 32'd7); wr(3'd2, 32'd1);
    idle(3);
    rd_chk(3'd4, 32'd7, "R3 enable loads and holds without tick");
    wr(3'd2, 32'd1);
    rd_chk(3'd4, 32'd7, "R3 second enable no reload");
    tick_on = 1'b1;
    idle(20);
    wr(3'd2, 32'd0);
    rd_chk(3'd4, m_cnt, "R3 count held while stopped");
    // R5 continuous, interrupt unmasked, tick every cycle then every third
    wr(3'd6, 32'd0); wr(3'd1, 32'd3); wr(3'd2, 32'd1);
    idle(12);
    tick_every = 3;
    idle(30);
    tick_every = 1;
    wr(3'd2, 32'd0);
    rd_chk(3'd5, 32'd1, "R5 pending set in continuous run");
    // R7 clear
    wr(3'd5, 32'd0);
    rd_chk(3'd5, 32'd1, "R7 write 0 no effect");
    wr(3'd5, 32'd1);
    rd_chk(3'd5, 32'd3, "R7 busy cycle 1");
    rd_chk(3'd5, 32'd3, "R7 busy cycle 2");
    rd_chk(3'd5, 32'd3, "R7 busy cycle 3");
    rd_chk(3'd5, 32'd0, "R7 clear done");
    // R8 writes during busy ignored
    wr(3'd5, 32'd1); wr(3'd5, 32'd1);
    rd_chk(3'd5, 32'd2, "R8 busy not restarted a");
    rd_chk(3'd5, 32'd2, "R8 busy not restarted b");
    rd_chk(3'd5, 32'd0, "R8 busy ends on time");
    // R8 terminal during clear, R6 single halt
    wr(3'd0, 32'd1); wr(3'd1, 32'd3); wr(3'd2, 32'd1);
    idle(1);
    wr(3'd5, 32'd1);
    idle(4);
    rd_chk(3'd5, 32'd1, "R8 late terminal keeps pending");
    rd_chk(3'd4, 32'd0, "R6 single holds zero");
    idle(10);
    rd_chk(3'd4, 32'd0, "R6 single still zero");
    wr(3'd3, 32'd0);
    idle(2);
    rd_chk(3'd4, 32'd1, "R6 restart resumes count");
    idle(6);
    rd_chk(3'd4, 32'd0, "R6 halted again");
    wr(3'd2, 32'd0); wr(3'd2, 32'd1);
    idle(8);
    rd_chk(3'd4, 32'd0, "R6 re-enable restart then halt");
    // R9 mask
    wr(3'd6, 32'd1);
    idle(2);
    chk("R9 masked irq low", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'd0);
    idle(2);
    chk("R9 unmasked irq high", {31'd0, irq}, 32'd1);
    // continuous with sparse ticks
    wr(3'd2, 32'd0); wr(3'd0, 32'd0); wr(3'd1, 32'd4); wr(3'd2, 32'd1);
    tick_every = 3;
    idle(40);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule